// File: doc/BRIEF.md
# Paravirtual Device Interrupt Status and Notification Unit

This block holds the interrupt cause register of a paravirtual device function on a PCI-style bus and produces its notifications. Two single-cycle strobes come in from the device core: one reports a configuration change, the other reports that a queue needs service. Depending on whether message-signalled interrupts (MSI-X) are enabled, the unit either records the cause and raises a level-sensitive legacy interrupt line, or requests a message-signalled interrupt.

The cause register is eight bits wide and is cleared by the act of reading it. This lets a legacy driver learn the cause and acknowledge it in one access. The configuration-change cause is recorded in every mode, so a driver using message interrupts can still tell that the configuration changed without scanning configuration space. A queue cause is recorded only in legacy mode. In message mode, a queue event becomes a strobe for an external per-queue vector mapper. A configuration event in message mode becomes a request on a valid/ready handshake that carries the table entry number held in the configuration vector register.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-high reset, the cause register, `rd_data`, `intx`, `msg_valid` and `queue_msg` are all zero.
- R2: A cycle with `rd_en` high places the cause register's current value on `rd_data` after that clock edge. `rd_data` then holds until the next read. The same edge clears the register to zero unless an event sets a bit in that cycle.
- R3: A read that leaves the register zero drops `intx` at the same edge.
- R4: A `cfg_event` sets bit 1 of the cause register at the next edge, whether `msix_en` is high or low.
- R5: When `msix_en` is low, a `queue_event` sets bit 0 at the next edge. `intx` rises no earlier than the bit becomes visible.
- R6: When `msix_en` is high, a `queue_event` leaves bit 0 unchanged and does not raise `intx`. Instead it pulses `queue_msg` high for one cycle after the edge.
- R7: When `msix_en` is high and `cfg_vector` is not 16'hFFFF, a `cfg_event` with no request pending raises `msg_valid` at the next edge, with `msg_vector` equal to `cfg_vector`.
- R8: When `cfg_vector` equals the no-vector code 16'hFFFF, a `cfg_event` in message mode issues no request, but bit 1 is still set.
- R9: If an event sets a bit in the same cycle as a read, the new bit survives the clear. `intx` stays high because of it in legacy mode.
- R10: `intx` is high exactly when `msix_en` was low and the register's next value was nonzero at the last edge. Message mode forces `intx` low.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and `msg_vector` hold. A further configuration event is merged into the pending request and creates no second request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_event | input | 1 | Configuration-change strobe |
| queue_event | input | 1 | Queue-notification strobe |
| msix_en | input | 1 | Message-signalled interrupt mode enable |
| cfg_vector | input | 16 | Table entry number for configuration messages; 16'hFFFF means none |
| rd_en | input | 1 | Read strobe for the cause register (read clears it) |
| rd_data | output | 8 | Value returned by the last read |
| intx | output | 1 | Level legacy interrupt line |
| msg_valid | output | 1 | Configuration message request pending |
| msg_vector | output | 16 | Table entry number of the pending request |
| msg_ready | input | 1 | Acceptance of the pending request |
| queue_msg | output | 1 | One-cycle queue message strobe for the external mapper |

## Verification
The assertions assume only that reset is applied before the first checked edge. They assume that `msg_ready` is sampled on the same edge as `msg_valid`. They place no limit on how the event strobes, reads and mode changes coincide. The stimulus keeps `cfg_vector` and `msix_en` constant over runs of cycles but changes them between phases. It deliberately puts reads on the same cycle as events, events on the same cycle as acceptances, and repeated events while a request waits. That way the merge, set-over-clear and no-vector paths are all exercised under the same rules the properties rely on.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned CAUSE_W  = 8;
  localparam int unsigned VEC_W    = 16;
  localparam int unsigned CFG_BIT  = 1;
  localparam int unsigned QUE_BIT  = 0;
  localparam logic [VEC_W-1:0] NO_VEC = {VEC_W{1'b1}};
endpackage

// File: rtl/cause_reg.sv
module cause_reg #(
  parameter int unsigned W       = 8,
  parameter int unsigned CFG_BIT = 1,
  parameter int unsigned QUE_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_set,
  input  logic         que_set,
  input  logic         rd_en,
  input  logic         msix_en,
  output logic [W-1:0] cause,
  output logic [W-1:0] rd_data,
  output logic         intx
);
  logic [W-1:0] set_bits;
  logic [W-1:0] cause_nx;
  logic [W-1:0] cause_q;
  logic [W-1:0] rd_q;
  logic         intx_q;

  always_comb begin
    set_bits          = '0;
    set_bits[CFG_BIT] = cfg_set;
    set_bits[QUE_BIT] = que_set;
    cause_nx          = (rd_en ? '0 : cause_q) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      rd_q    <= '0;
      intx_q  <= 1'b0;
    end else begin
      cause_q <= cause_nx;
      if (rd_en) rd_q <= cause_q;
      intx_q  <= !msix_en && (cause_nx != '0);
    end
  end

  assign cause   = cause_q;
  assign rd_data = rd_q;
  assign intx    = intx_q;

  // R2
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !cfg_set && !que_set) |=> (cause_q == '0));
  // R2
  rd_value_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_q == $past(cause_q)));
  // R3
  rd_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !cfg_set && !que_set) |=> !intx_q);
  // R4
  cfg_bit_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_set |=> cause_q[CFG_BIT]);
  // R5
  que_bit_chk: assert property (@(posedge clk) disable iff (rst)
    que_set |=> cause_q[QUE_BIT]);
  // R10
  msix_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    msix_en |=> !intx_q);
  // R9
  survive_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cfg_set && !msix_en) |=> (intx_q && cause_q[CFG_BIT]));
endmodule

// File: rtl/cfg_msg_req.sv
module cfg_msg_req #(
  parameter int unsigned VW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [VW-1:0] vector,
  input  logic          ready,
  output logic          valid,
  output logic [VW-1:0] vec
);
  logic          valid_q;
  logic [VW-1:0] vec_q;
  logic          free;

  assign free = !valid_q || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (valid_q && ready) valid_q <= 1'b0;
      if (fire && free) begin
        valid_q <= 1'b1;
        vec_q   <= vector;
      end
    end
  end

  assign valid = valid_q;
  assign vec   = vec_q;

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready) |=> (valid_q && $stable(vec_q)));
  // R7
  issue_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !valid_q) |=> (valid_q && vec_q == $past(vector)));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_event,
  input  logic               queue_event,
  input  logic               msix_en,
  input  logic [VEC_W-1:0]   cfg_vector,
  input  logic               rd_en,
  output logic [CAUSE_W-1:0] rd_data,
  output logic               intx,
  output logic               msg_valid,
  output logic [VEC_W-1:0]   msg_vector,
  input  logic               msg_ready,
  output logic               queue_msg
);
  logic [CAUSE_W-1:0] cause;
  logic               que_set;
  logic               cfg_fire;
  logic               qmsg_q;

  assign que_set  = queue_event && !msix_en;
  assign cfg_fire = cfg_event && msix_en && (cfg_vector != NO_VEC);

  cause_reg #(.W(CAUSE_W), .CFG_BIT(CFG_BIT), .QUE_BIT(QUE_BIT)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .cfg_set (cfg_event),
    .que_set (que_set),
    .rd_en   (rd_en),
    .msix_en (msix_en),
    .cause   (cause),
    .rd_data (rd_data),
    .intx    (intx)
  );

  cfg_msg_req #(.VW(VEC_W)) u_req (
    .clk    (clk),
    .rst    (rst),
    .fire   (cfg_fire),
    .vector (cfg_vector),
    .ready  (msg_ready),
    .valid  (msg_valid),
    .vec    (msg_vector)
  );

  always_ff @(posedge clk) begin
    if (rst) qmsg_q <= 1'b0;
    else     qmsg_q <= queue_event && msix_en;
  end
  assign queue_msg = qmsg_q;

  // R6
  qmsg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (msix_en && queue_event) |=> queue_msg);
  // R6
  qbit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (msix_en && queue_event && !rd_en) |=> (cause[QUE_BIT] == $past(cause[QUE_BIT])));
  // R8
  novec_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_event && msix_en && cfg_vector == NO_VEC && !msg_valid) |=> !msg_valid);
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_event = 1'b0;
  logic        queue_event = 1'b0;
  logic        msix_en = 1'b0;
  logic [15:0] cfg_vector = 16'h0000;
  logic        rd_en = 1'b0;
  logic        msg_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        intx;
  logic        msg_valid;
  logic [15:0] msg_vector;
  logic        queue_msg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  logic [7:0]  m_cause;
  logic [7:0]  m_rd;
  logic        m_intx;
  logic        m_valid;
  logic [15:0] m_vec;
  logic        m_qmsg;
  logic [15:0] issued[$];
  int          accepted = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst(rst), .cfg_event(cfg_event), .queue_event(queue_event),
    .msix_en(msix_en), .cfg_vector(cfg_vector), .rd_en(rd_en),
    .rd_data(rd_data), .intx(intx), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_ready(msg_ready), .queue_msg(queue_msg)
  );

  always @(posedge clk) begin
    logic [7:0] nxt;
    if (rst) begin
      m_cause = 8'h00; m_rd = 8'h00; m_intx = 1'b0;
      m_valid = 1'b0;  m_vec = 16'h0000; m_qmsg = 1'b0;
    end else begin
      nxt = rd_en ? 8'h00 : m_cause;
      if (cfg_event) nxt[1] = 1'b1;
      if (queue_event && !msix_en) nxt[0] = 1'b1;
      if (rd_en) m_rd = m_cause;
      m_cause = nxt;
      m_intx  = !msix_en && (nxt != 8'h00);
      m_qmsg  = queue_event && msix_en;
      if (m_valid && msg_ready) begin
        m_valid = 1'b0;
        if (issued.size() > 0) void'(issued.pop_front());
        accepted++;
      end
      if (cfg_event && msix_en && cfg_vector != 16'hFFFF && !m_valid) begin
        m_valid = 1'b1;
        m_vec   = cfg_vector;
        issued.push_back(cfg_vector);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(rd_data == m_rd, "R2 rd_data", 32'(rd_data), 32'(m_rd));
    chk(intx == m_intx, "R3/R5/R9/R10 intx", 32'(intx), 32'(m_intx));
    chk(queue_msg == m_qmsg, "R6 queue_msg", 32'(queue_msg), 32'(m_qmsg));
    chk(msg_valid == m_valid, "R7/R8/R11 msg_valid", 32'(msg_valid), 32'(m_valid));
    if (m_valid)
      chk(msg_vector == m_vec, "R7/R11 msg_vector", 32'(msg_vector), 32'(m_vec));
  endtask

  task automatic cyc(input bit c, input bit q, input bit r, input bit rdy);
    cfg_event = c; queue_event = q; rd_en = r; msg_ready = rdy;
    @(negedge clk);
    compare_all();
    cfg_event = 1'b0; queue_event = 1'b0; rd_en = 1'b0; msg_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 8'h00 && !intx && !msg_valid && !queue_msg, "R1 reset outputs",
        {rd_data, 3'b0, intx, 3'b0, msg_valid, 3'b0, queue_msg}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    compare_all();

    // legacy mode: queue event, then read
    msix_en = 1'b0;
    cyc(0, 1, 0, 0);
    chk(intx == 1'b1, "R5 legacy queue raises intx", 32'(intx), 32'h1);
    cyc(0, 0, 1, 0);
    chk(rd_data == 8'h01, "R2 read returns queue cause", 32'(rd_data), 32'h01);
    chk(intx == 1'b0, "R3 read drops intx", 32'(intx), 32'h0);
    cyc(0, 0, 1, 0);
    chk(rd_data == 8'h00, "R2 second read sees cleared value", 32'(rd_data), 32'h00);

    // legacy: config and queue together, then read colliding with config event
    cyc(1, 1, 0, 0);
    cyc(1, 0, 1, 0);
    chk(rd_data == 8'h03, "R4 both causes returned", 32'(rd_data), 32'h03);
    chk(intx == 1'b1, "R9 new bit survives clear", 32'(intx), 32'h1);
    cyc(0, 0, 1, 0);
    chk(rd_data == 8'h02, "R9 surviving config bit read", 32'(rd_data), 32'h02);

    // message mode: queue event goes to mapper
    msix_en = 1'b1;
    cfg_vector = 16'h0005;
    cyc(0, 1, 0, 0);
    chk(queue_msg == 1'b1 && intx == 1'b0, "R6 queue strobe, no intx",
        {queue_msg, intx}, 32'h2);
    cyc(0, 0, 0, 0);
    chk(queue_msg == 1'b0, "R6 strobe lasts one cycle", 32'(queue_msg), 32'h0);
    cyc(0, 0, 1, 0);
    chk(rd_data == 8'h00, "R6 queue bit not set in message mode", 32'(rd_data), 32'h00);

    // message mode: config request, merge, accept
    cyc(1, 0, 0, 0);
    chk(msg_valid && msg_vector == 16'h0005, "R7 request issued", 32'(msg_vector), 32'h0005);
    chk(intx == 1'b0, "R10 intx forced low in message mode", 32'(intx), 32'h0);
    cfg_vector = 16'h0009;
    cyc(1, 0, 0, 0);
    chk(msg_vector == 16'h0005, "R11 pending vector held, event merged", 32'(msg_vector), 32'h0005);
    cyc(0, 0, 0, 1);
    chk(msg_valid == 1'b0, "R11 merged event yields no second request", 32'(msg_valid), 32'h0);
    cyc(0, 0, 1, 0);
    chk(rd_data == 8'h02, "R4 config bit set in message mode", 32'(rd_data), 32'h02);

    // no-vector code
    cfg_vector = 16'hFFFF;
    cyc(1, 0, 0, 0);
    chk(msg_valid == 1'b0, "R8 no request for 16'hFFFF", 32'(msg_valid), 32'h0);
    cyc(0, 0, 1, 0);
    chk(rd_data == 8'h02, "R8 config bit still set", 32'(rd_data), 32'h02);

    // pending status while switching back to legacy raises intx
    cyc(1, 0, 0, 0);
    msix_en = 1'b0;
    cyc(0, 0, 0, 0);
    chk(intx == 1'b1, "R10 legacy mode with nonzero cause", 32'(intx), 32'h1);
    cyc(0, 0, 1, 0);

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      msix_en = ph[0];
      cfg_vector = (ph % 3 == 0) ? 16'hFFFF : 16'(ph * 16'h0111);
      for (int i = 0; i < 400; i++) begin
        cyc(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0);
      end
    end
    chk(accepted > 0, "R7 requests accepted in random run", 32'(accepted), 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule